// File: doc/BRIEF.md
# Multiplexed Bus Wait-State Sequencer

This block steps each access on a shared address/data external bus through its base states T1 to T5. It can add an address-wait state after T1 and a run of data-wait states after T4. A requester offers an access on a valid/ready pair. The block takes it only when idle and holds ready low until the access has finished. There is no back-pressure inside an access: once taken, the access always runs to completion.

Each region has its own address-wait enable and its own wait-insertion mode, held as per-region configuration vectors. One designated region takes its 2-bit data-wait count from a field of its own; every other region uses one shared field. There are three modes. In programmed mode the count is fixed and the WAIT input has no effect. In pin mode the programmed waits come first, and WAIT can then stretch the access for as long as it stays low. In auto mode the programmed count is added only when WAIT is low during T4, and never more than that count.

WAIT is captured on the falling clock edge, halfway through a state. The state machine uses that captured value at the next rising edge. The current state is visible on a port, together with an address-latch strobe, read and write data strobes, and a done pulse.

Top module: `mbs_wait_seq`

## Requirements
- R1: `req_ready` is high exactly when `bus_state` is idle (code 0). A rising edge with `req_valid` and `req_ready` both high moves the block to T1. Region, write flag and that region's configuration are captured at that edge and used for the whole access.
- R2: State codes are: idle 0, T1 1, address wait 2, T2 3, T3 4, T4 5, programmed wait 6, pin/auto wait 7, T5 8. Every access runs T1, T2, T3, T4 and T5 once each, in that order, then returns to idle.
- R3: One address-wait state (code 2) sits between T1 and T2 exactly when bit r of `cfg_aw_en` is set for the accessed region r. Otherwise there is none.
- R4: Region `SPECIAL_REGION` (default 3) takes its wait count from `cfg_wcnt_special`. All other regions take it from `cfg_wcnt_common`.
- R5: Mode field `cfg_mode[2r+1:2r]` values 00 and 11 select programmed mode: exactly N programmed-wait states (code 6) follow T4, where N is the wait count. `wait_n` has no effect on the access.
- R6: Mode 01 (pin) inserts N programmed-wait states first. Then, whenever `wait_n` is low at the falling edge within the last T4, programmed-wait or pin-wait state, one more pin-wait state (code 7) follows, with no upper limit.
- R7: Mode 10 (auto) inserts exactly N pin-wait states (code 7) when `wait_n` is low at the falling edge within T4, whatever `wait_n` does afterwards. If `wait_n` is high there, it inserts none.
- R8: `ale` is high only in T1, and in every T1.
- R9: `rd_stb` (read access) or `wr_stb` (write access) is high in T3, T4, all data-wait states and T5, and low elsewhere. The two are never high together.
- R10: `done` is high for exactly the one T5 cycle of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_region | input | $clog2(NUM_REGIONS) | Region of the requested access |
| cfg_aw_en | input | NUM_REGIONS | Per-region address-wait enable |
| cfg_mode | input | 2*NUM_REGIONS | Per-region wait mode, 2 bits each |
| cfg_wcnt_common | input | CNT_W | Wait count shared by ordinary regions |
| cfg_wcnt_special | input | CNT_W | Wait count of the designated region |
| wait_n | input | 1 | Active-low external wait request |
| bus_state | output | 4 | Current state code |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read data strobe |
| wr_stb | output | 1 | Write data strobe |
| done | output | 1 | Access completion pulse |

## Verification
Every cycle, the assertions check the legal successor of each base state, that an address wait appears only for an enabled region, that programmed mode never enters a pin-wait state, and that auto mode never exceeds its count. They also check that the two data strobes never overlap, that an accepted request leads straight to T1, and that T5 is always followed by idle. Only the bench's sweep can show the exact number of waits for each combination of mode, count and WAIT-low duration. The same holds for which count field a region selects, and for strobe and done timing measured against the observed states.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_T1   = 4'd1,
    ST_AW   = 4'd2,
    ST_T2   = 4'd3,
    ST_T3   = 4'd4,
    ST_T4   = 4'd5,
    ST_PW   = 4'd6,
    ST_XW   = 4'd7,
    ST_T5   = 4'd8
  } bus_st_e;

  localparam logic [1:0] MODE_PROG = 2'b00;
  localparam logic [1:0] MODE_PIN  = 2'b01;
  localparam logic [1:0] MODE_AUTO = 2'b10;
endpackage

// File: rtl/mbs_cfg_sel.sv
module mbs_cfg_sel #(
  parameter int NUM_REGIONS    = 4,
  parameter int SPECIAL_REGION = 3,
  parameter int CNT_W          = 2,
  localparam int RW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [RW-1:0]            region,
  input  logic [NUM_REGIONS-1:0]   aw_en_vec,
  input  logic [2*NUM_REGIONS-1:0] mode_vec,
  input  logic [CNT_W-1:0]         cnt_common,
  input  logic [CNT_W-1:0]         cnt_special,
  output logic                     sel_aw,
  output logic [1:0]               sel_mode,
  output logic [CNT_W-1:0]         sel_cnt
);
  logic [1:0] mode_arr [NUM_REGIONS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : g_unpack
      assign mode_arr[g] = mode_vec[2*g +: 2];
    end
  endgenerate

  always_comb begin
    sel_aw   = 1'b0;
    sel_mode = 2'b00;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (region == RW'(i)) begin
        sel_aw   = aw_en_vec[i];
        sel_mode = mode_arr[i];
      end
    end
    sel_cnt = (region == RW'(SPECIAL_REGION)) ? cnt_special : cnt_common;
  end
endmodule

// File: rtl/mbs_wait_smp.sv
module mbs_wait_smp (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  output logic wait_low
);
  // Captured halfway through each state, consumed at the following rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wait_low <= 1'b0;
    else        wait_low <= ~wait_n;
  end
endmodule

// File: rtl/mbs_seq_fsm.sv
module mbs_seq_fsm
  import mbs_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             sel_aw,
  input  logic [1:0]       sel_mode,
  input  logic [CNT_W-1:0] sel_cnt,
  input  logic             wait_low,
  output bus_st_e          st,
  output logic             wr_q,
  output logic             req_ready
);
  bus_st_e          nxt;
  logic             aw_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q, rem_q, rem_d;
  logic             is_pin, is_auto;

  assign is_pin    = (mode_q == MODE_PIN);
  assign is_auto   = (mode_q == MODE_AUTO);
  assign req_ready = (st == ST_IDLE);

  always_comb begin
    nxt   = st;
    rem_d = rem_q;
    unique case (st)
      ST_IDLE: if (req_valid) nxt = ST_T1;
      ST_T1:   nxt = aw_q ? ST_AW : ST_T2;
      ST_AW:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3:   nxt = ST_T4;
      ST_T4: begin
        if (is_auto) begin
          if (wait_low && cnt_q != '0) begin
            nxt   = ST_XW;
            rem_d = cnt_q - 1'b1;
          end else begin
            nxt = ST_T5;
          end
        end else if (cnt_q != '0) begin
          nxt   = ST_PW;
          rem_d = cnt_q - 1'b1;
        end else if (is_pin && wait_low) begin
          nxt = ST_XW;
        end else begin
          nxt = ST_T5;
        end
      end
      ST_PW: begin
        if (rem_q != '0) begin
          nxt   = ST_PW;
          rem_d = rem_q - 1'b1;
        end else if (is_pin && wait_low) begin
          nxt = ST_XW;
        end else begin
          nxt = ST_T5;
        end
      end
      ST_XW: begin
        if (is_auto) begin
          if (rem_q != '0) begin
            nxt   = ST_XW;
            rem_d = rem_q - 1'b1;
          end else begin
            nxt = ST_T5;
          end
        end else begin
          nxt = wait_low ? ST_XW : ST_T5;
        end
      end
      ST_T5:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rem_q  <= '0;
      aw_q   <= 1'b0;
      mode_q <= MODE_PROG;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      st    <= nxt;
      rem_q <= rem_d;
      if (st == ST_IDLE && req_valid) begin
        aw_q   <= sel_aw;
        mode_q <= sel_mode;
        cnt_q  <= sel_cnt;
        wr_q   <= req_write;
      end
    end
  end

  // Checker state: auto-mode extra waits seen in the current access.
  logic [CNT_W:0] xw_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            xw_seen <= '0;
    else if (st == ST_T4)  xw_seen <= '0;
    else if (st == ST_XW)  xw_seen <= xw_seen + 1'b1;
  end

  // R1
  accept_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid) |=> (st == ST_T1));
  // R2
  t1_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1) |=> (st == ST_AW || st == ST_T2));
  // R2
  t2_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2) |=> (st == ST_T3));
  // R2
  t3_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T3) |=> (st == ST_T4));
  // R2
  t5_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T5) |=> (st == ST_IDLE));
  // R3
  aw_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AW) |-> (aw_q && $past(st) == ST_T1));
  // R5
  prog_no_pinwait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_pin && !is_auto) |-> (st != ST_XW));
  // R7
  auto_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_auto && st == ST_XW) |-> (xw_seen < {1'b0, cnt_q}));
  // R7
  auto_no_progwait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_auto |-> (st != ST_PW));
endmodule

// File: rtl/mbs_strobe_gen.sv
module mbs_strobe_gen
  import mbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_st_e st,
  input  logic    wr_q,
  output logic    ale,
  output logic    rd_stb,
  output logic    wr_stb,
  output logic    done
);
  logic data_phase;

  always_comb begin
    unique case (st)
      ST_T3, ST_T4, ST_PW, ST_XW, ST_T5: data_phase = 1'b1;
      default:                           data_phase = 1'b0;
    endcase
  end

  assign ale    = (st == ST_T1);
  assign rd_stb = data_phase & ~wr_q;
  assign wr_stb = data_phase &  wr_q;
  assign done   = (st == ST_T5);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  ale_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !(rd_stb || wr_stb || done));
endmodule

// File: rtl/mbs_wait_seq.sv
module mbs_wait_seq
  import mbs_pkg::*;
#(
  parameter int NUM_REGIONS    = 4,
  parameter int SPECIAL_REGION = NUM_REGIONS - 1,
  parameter int CNT_W          = 2,
  localparam int RW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [RW-1:0]            req_region,
  input  logic [NUM_REGIONS-1:0]   cfg_aw_en,
  input  logic [2*NUM_REGIONS-1:0] cfg_mode,
  input  logic [CNT_W-1:0]         cfg_wcnt_common,
  input  logic [CNT_W-1:0]         cfg_wcnt_special,
  input  logic                     wait_n,
  output logic [3:0]               bus_state,
  output logic                     ale,
  output logic                     rd_stb,
  output logic                     wr_stb,
  output logic                     done
);
  logic             sel_aw;
  logic [1:0]       sel_mode;
  logic [CNT_W-1:0] sel_cnt;
  logic             wait_low;
  logic             wr_q;
  bus_st_e          st;

  mbs_cfg_sel #(
    .NUM_REGIONS(NUM_REGIONS), .SPECIAL_REGION(SPECIAL_REGION), .CNT_W(CNT_W)
  ) u_cfg (
    .region(req_region), .aw_en_vec(cfg_aw_en), .mode_vec(cfg_mode),
    .cnt_common(cfg_wcnt_common), .cnt_special(cfg_wcnt_special),
    .sel_aw(sel_aw), .sel_mode(sel_mode), .sel_cnt(sel_cnt)
  );

  mbs_wait_smp u_smp (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n), .wait_low(wait_low)
  );

  mbs_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .sel_aw(sel_aw), .sel_mode(sel_mode), .sel_cnt(sel_cnt),
    .wait_low(wait_low), .st(st), .wr_q(wr_q), .req_ready(req_ready)
  );

  mbs_strobe_gen u_stb (
    .clk(clk), .rst_n(rst_n), .st(st), .wr_q(wr_q),
    .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
  );

  assign bus_state = st;
endmodule

// File: tb/mbs_wait_seq_bench.sv
module mbs_wait_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [1:0] req_region = '0;
  logic [3:0] cfg_aw_en = '0;
  logic [7:0] cfg_mode = '0;
  logic [1:0] cfg_wcnt_common = '0;
  logic [1:0] cfg_wcnt_special = '0;
  logic       wait_n = 1'b1;
  logic [3:0] bus_state;
  logic       ale, rd_stb, wr_stb, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbs_wait_seq u_mbs_wait_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_region(req_region), .cfg_aw_en(cfg_aw_en),
    .cfg_mode(cfg_mode), .cfg_wcnt_common(cfg_wcnt_common),
    .cfg_wcnt_special(cfg_wcnt_special), .wait_n(wait_n),
    .bus_state(bus_state), .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // One access: region r, write w, address wait aw, count n, mode m, WAIT low for L cycles from T4.
  task automatic run_access(input int r, input bit w, input bit aw, input int n,
                            input int m, input int lo);
    int cnt_aw = 0, cnt_pw = 0, cnt_xw = 0, cnt_done = 0;
    int cnt_t1 = 0, cnt_t2 = 0, cnt_t3 = 0, cnt_t4 = 0, cnt_t5 = 0;
    int k = -1, guard = 0;
    bit order_ok = 1, stb_ok = 1, ale_ok = 1, ready_ok = 1;
    int prev;
    int exp_pw, exp_xw;
    // Configuration: the region under test gets (aw, m, n); all others differ.
    for (int i = 0; i < 4; i++) begin
      cfg_aw_en[i]      = (i == r) ? aw : ~aw;
      cfg_mode[2*i +: 2] = (i == r) ? 2'(m) : 2'(m ^ 1);
    end
    if (r == 3) begin
      cfg_wcnt_special = 2'(n); cfg_wcnt_common = 2'(3 - n);
    end else begin
      cfg_wcnt_common = 2'(n); cfg_wcnt_special = 2'(3 - n);
    end
    exp_pw = (m == 0 || m == 3 || m == 1) ? n : 0;
    if (m == 1)      exp_xw = (lo > n) ? lo - n : 0;
    else if (m == 2) exp_xw = (lo > 0 && n > 0) ? n : 0;
    else             exp_xw = 0;

    req_region = 2'(r);
    req_write  = w;
    req_valid  = 1'b1;
    wait_n     = (lo == 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    // R1: accepted request shows T1 next cycle
    check(bus_state == 4'd1, "R1 accept->T1", bus_state, 1);
    // Scramble configuration to prove it was captured at acceptance (R1).
    cfg_aw_en = ~cfg_aw_en;
    cfg_mode  = ~cfg_mode;
    cfg_wcnt_common  = ~cfg_wcnt_common;
    cfg_wcnt_special = ~cfg_wcnt_special;
    req_write = ~w;
    prev = 0;
    while (bus_state != 4'd0 && guard < 40) begin
      guard++;
      if (bus_state == 4'd5) k = 0;
      else if (k >= 0) k++;
      wait_n = (k < 0) ? (lo == 0) : !(k < lo);
      case (bus_state)
        4'd1: cnt_t1++;
        4'd2: cnt_aw++;
        4'd3: cnt_t2++;
        4'd4: cnt_t3++;
        4'd5: cnt_t4++;
        4'd6: cnt_pw++;
        4'd7: cnt_xw++;
        4'd8: cnt_t5++;
        default: order_ok = 0;
      endcase
      case (bus_state)
        4'd1: if (prev != 0) order_ok = 0;
        4'd2: if (prev != 1) order_ok = 0;
        4'd3: if (prev != 1 && prev != 2) order_ok = 0;
        4'd4: if (prev != 3) order_ok = 0;
        4'd5: if (prev != 4) order_ok = 0;
        4'd6: if (prev != 5 && prev != 6) order_ok = 0;
        4'd7: if (prev != 5 && prev != 6 && prev != 7) order_ok = 0;
        4'd8: if (prev != 5 && prev != 6 && prev != 7) order_ok = 0;
        default: ;
      endcase
      if (ale != (bus_state == 4'd1)) ale_ok = 0;
      if (rd_stb != (!w && bus_state >= 4'd4 && bus_state <= 4'd8)) stb_ok = 0;
      if (wr_stb != ( w && bus_state >= 4'd4 && bus_state <= 4'd8)) stb_ok = 0;
      if (done) cnt_done++;
      if (done != (bus_state == 4'd8)) cnt_done += 10;
      if (req_ready) ready_ok = 0;
      prev = int'(bus_state);
      @(posedge clk); #1;
    end
    wait_n = 1'b1;
    if (prev != 8) order_ok = 0;
    check(order_ok && cnt_t1 == 1 && cnt_t2 == 1 && cnt_t3 == 1 && cnt_t4 == 1 && cnt_t5 == 1,
          "R2 state order", prev, 8);
    check(cnt_aw == int'(aw), "R3 address wait", cnt_aw, int'(aw));
    if (m == 1) begin
      check(cnt_pw == exp_pw, "R6 pin programmed waits", cnt_pw, exp_pw);
      check(cnt_xw == exp_xw, "R6 pin extra waits", cnt_xw, exp_xw);
    end else if (m == 2) begin
      check(cnt_pw == exp_pw, "R7 auto no programmed", cnt_pw, exp_pw);
      check(cnt_xw == exp_xw, "R7 auto waits", cnt_xw, exp_xw);
    end else begin
      check(cnt_pw == exp_pw, "R5 programmed waits", cnt_pw, exp_pw);
      check(cnt_xw == 0, "R5 wait_n ignored", cnt_xw, 0);
    end
    // R4: count source depends on region; wrong source gives 3-n waits
    if (m != 2 || lo > 0)
      check(cnt_pw + cnt_xw == exp_pw + exp_xw, "R4 count field", cnt_pw + cnt_xw, exp_pw + exp_xw);
    check(ale_ok, "R8 ale", int'(ale_ok), 1);
    check(stb_ok, "R9 data strobes", int'(stb_ok), 1);
    check(cnt_done == 1, "R10 done pulse", cnt_done, 1);
    check(ready_ok && req_ready, "R1 ready only when idle", int'(ready_ok), 1);
  endtask

  initial begin
    int los[4] = '{0, 1, 2, 5};
    #20;
    // Reset state
    check(bus_state == 4'd0, "R2 reset idle", bus_state, 0);
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    check(!ale && !rd_stb && !wr_stb && !done, "R9 reset strobes",
          int'({ale, rd_stb, wr_stb, done}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(bus_state == 4'd0, "R1 idle without request", bus_state, 0);
    for (int r = 0; r < 4; r++)
      for (int aw = 0; aw < 2; aw++)
        for (int n = 0; n < 4; n++)
          for (int m = 0; m < 4; m++)
            for (int li = 0; li < 4; li++)
              run_access(r, bit'((r + n + li) & 1), bit'(aw), n, m, los[li]);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule